// File: doc/BRIEF.md
# Built-in Self-Test Pattern and Signature Engine

This block tests a small combinational circuit on chip. A linear feedback shift register makes a pseudo-random pattern each clock and drives it onto `pat_out`. The circuit's reply comes back on `resp_in`. A second feedback register folds that reply into a signature, one step per clock. When a test starts, the block latches the requested length and the expected signature. It then runs for exactly that many clocks and unloads the final signature serially. After the unload it raises `done`, and `pass` reports whether the signature matched.

Only the final signature is kept; the response stream is never stored. For an m-bit response stream and an n-bit signature, a faulty stream matches the good one with a probability of about (2^(m-n)-1)/(2^m-1). The integrator should therefore choose test lengths much longer than the signature width. The pattern register walks all 2^n-1 nonzero values before it repeats. The signature register can take any value, including zero.

The controller has four states. IDLE is the state after reset. RUN applies patterns and compacts responses. UNLOAD shifts the signature out. DONE holds the verdict. Its transitions are:
- LAUNCH: IDLE or DONE goes to RUN when `start` arrives with a nonzero length.
- SKIP: IDLE or DONE goes to UNLOAD when `start` arrives with a zero length.
- FINISH_RUN: RUN goes to UNLOAD after the last run clock.
- FINISH_UNLOAD: UNLOAD goes to DONE after the last signature bit.
- RELAUNCH: this is LAUNCH or SKIP taken from DONE.

Top module: `bist_engine`

## Requirements
- R1: After reset `done`, `pass` and `sig_ser_valid` are 0, and `pat_out` holds the seed 0001.
- R2: In RUN the first pattern is 0001 and each clock the next is {p[2:0], p[3]^p[2]}. This gives a period of 15, and the pattern is never 0000.
- R3: A test started with length L spends exactly L clocks in RUN, so the pattern advances exactly L times.
- R4: The signature starts at 0000 on each start. Each RUN clock it becomes {s[2:0], s[3]^s[0]} XOR r, where r is the `resp_in` value seen with the current pattern.
- R5: After RUN, `sig_ser_valid` is 1 for exactly 4 clocks and `sig_ser` gives the signature MSB first. `sig_ser` is 0 whenever `sig_ser_valid` is 0.
- R6: `done` rises on the clock after the last unload bit and stays 1 until the next accepted start. `pass` is 1 only while `done` is 1 and the signature equals the golden value.
- R7: `start` is ignored in RUN and UNLOAD.
- R8: A length of 0 skips RUN: the unload begins on the next clock and shows 0000.
- R9: Outside RUN the pattern output holds its value.
- R10: `golden` is captured when a start is accepted; later changes have no effect on `pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (taken in IDLE or DONE) |
| test_len | input | 16 | Number of RUN clocks |
| golden | input | 4 | Expected signature |
| pat_out | output | 4 | Pattern to the circuit under test |
| resp_in | input | 4 | Response from the circuit under test |
| sig_ser | output | 1 | Serial signature, MSB first |
| sig_ser_valid | output | 1 | Serial signature bit valid |
| done | output | 1 | Test finished |
| pass | output | 1 | Signature matched golden (with done) |

## Verification
The hardest cases to reach from the ports are a `start` that arrives while the engine is busy and a `golden` change in the middle of a run. Neither leaves a visible trace unless the rest of the test is followed to its end. The stimulus therefore pulses `start` during RUN and during UNLOAD, with a new length and an inverted golden value. It then checks that the pattern sequence, the unload length, the serial bits and the verdict all follow the original request. Random lengths and golden values are mixed with directed runs of zero, one and a full period.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_UNLOAD = 2'd2,
        ST_DONE   = 2'd3
    } bist_state_e;

    typedef enum logic [1:0] {
        PAT_HOLD = 2'd0,
        PAT_SEED = 2'd1,
        PAT_STEP = 2'd2
    } pat_op_e;

    typedef enum logic [1:0] {
        SIG_HOLD    = 2'd0,
        SIG_CLEAR   = 2'd1,
        SIG_COMPACT = 2'd2,
        SIG_ROTATE  = 2'd3
    } sig_op_e;

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
    import bist_pkg::*;
#(
    parameter int          W    = 4,
    parameter logic [W-1:0] TAPS = 4'b1100,
    parameter logic [W-1:0] SEED = 4'b0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pat_op_e      op,
    output logic [W-1:0] q
);

    // An all-zero seed would lock the register; fall back to 1.
    localparam logic [W-1:0] SEED_OK = (SEED == '0) ? W'(1) : SEED;

    logic [W-1:0] q_r;
    logic         fb;

    always_comb begin
        fb = ^(q_r & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= SEED_OK;
        end else begin
            unique case (op)
                PAT_SEED: q_r <= SEED_OK;
                PAT_STEP: q_r <= {q_r[W-2:0], fb};
                default:  q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/bist_sig_compactor.sv
module bist_sig_compactor
    import bist_pkg::*;
#(
    parameter int           SW   = 4,
    parameter int           RW   = 4,
    parameter logic [SW-1:0] TAPS = 4'b1001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sig_op_e       op,
    input  logic [RW-1:0] resp,
    output logic [SW-1:0] q
);

    logic [SW-1:0] q_r;
    logic [SW-1:0] folded;
    logic          fb;

    // Fold a response wider than the signature onto its stages.
    always_comb begin
        folded = '0;
        for (int j = 0; j < RW; j++) begin
            folded[j % SW] = folded[j % SW] ^ resp[j];
        end
    end

    always_comb begin
        fb = ^(q_r & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            unique case (op)
                SIG_CLEAR:   q_r <= '0;
                SIG_COMPACT: q_r <= {q_r[SW-2:0], fb} ^ folded;
                SIG_ROTATE:  q_r <= {q_r[SW-2:0], q_r[SW-1]};
                default:     q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int SIG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] test_len,
    output bist_state_e      state,
    output logic             accept,
    output pat_op_e          pat_op,
    output sig_op_e          sig_op,
    output logic             ser_valid,
    output logic             done
);

    localparam logic [LEN_W-1:0] UNL_LAST = LEN_W'(SIG_W - 1);

    bist_state_e      state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign accept   = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    if (test_len == '0) begin
                        state_d = ST_UNLOAD;
                        cnt_d   = UNL_LAST;
                    end else begin
                        state_d = ST_RUN;
                        cnt_d   = test_len - LEN_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (cnt_zero) begin
                    state_d = ST_UNLOAD;
                    cnt_d   = UNL_LAST;
                end else begin
                    cnt_d = cnt_q - LEN_W'(1);
                end
            end
            ST_UNLOAD: begin
                if (cnt_zero) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - LEN_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        pat_op    = PAT_HOLD;
        sig_op    = SIG_HOLD;
        ser_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    pat_op = PAT_SEED;
                    sig_op = SIG_CLEAR;
                end
            end
            ST_RUN: begin
                pat_op = PAT_STEP;
                sig_op = SIG_COMPACT;
            end
            ST_UNLOAD: begin
                sig_op    = SIG_ROTATE;
                ser_valid = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                if (accept) begin
                    pat_op = PAT_SEED;
                    sig_op = SIG_CLEAR;
                end
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bist_engine.sv
module bist_engine
    import bist_pkg::*;
#(
    parameter int              PAT_W    = 4,
    parameter logic [PAT_W-1:0] PAT_TAPS = 4'b1100,
    parameter logic [PAT_W-1:0] PAT_SEED = 4'b0001,
    parameter int              SIG_W    = 4,
    parameter logic [SIG_W-1:0] SIG_TAPS = 4'b1001,
    parameter int              RESP_W   = 4,
    parameter int              LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  test_len,
    input  logic [SIG_W-1:0]  golden,
    output logic [PAT_W-1:0]  pat_out,
    input  logic [RESP_W-1:0] resp_in,
    output logic              sig_ser,
    output logic              sig_ser_valid,
    output logic              done,
    output logic              pass
);

    bist_state_e      state;
    logic             accept;
    pat_op_e          pat_op;
    sig_op_e          sig_op;
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] golden_q;

    bist_ctrl #(
        .LEN_W (LEN_W),
        .SIG_W (SIG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .test_len  (test_len),
        .state     (state),
        .accept    (accept),
        .pat_op    (pat_op),
        .sig_op    (sig_op),
        .ser_valid (sig_ser_valid),
        .done      (done)
    );

    bist_pattern_gen #(
        .W    (PAT_W),
        .TAPS (PAT_TAPS),
        .SEED (PAT_SEED)
    ) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (pat_op),
        .q     (pat_out)
    );

    bist_sig_compactor #(
        .SW   (SIG_W),
        .RW   (RESP_W),
        .TAPS (SIG_TAPS)
    ) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (sig_op),
        .resp  (resp_in),
        .q     (sig_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            golden_q <= '0;
        end else if (accept) begin
            golden_q <= golden;
        end
    end

    // The rotate restores the signature after SIG_W steps, so DONE compares it whole.
    assign sig_ser = sig_ser_valid & sig_q[SIG_W-1];
    assign pass    = done && (sig_q == golden_q);

endmodule

// File: rtl/bist_engine_chk.sv
module bist_engine_chk
    import bist_pkg::*;
#(
    parameter int              PAT_W    = 4,
    parameter logic [PAT_W-1:0] PAT_TAPS = 4'b1100,
    parameter int              SIG_W    = 4,
    parameter int              LEN_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] test_len,
    input logic [PAT_W-1:0] pat_out,
    input logic             sig_ser,
    input logic             sig_ser_valid,
    input logic             done,
    input logic             pass,
    input bist_state_e      state
);

    function automatic logic [PAT_W-1:0] pat_next(input logic [PAT_W-1:0] p);
        return {p[PAT_W-2:0], ^(p & PAT_TAPS)};
    endfunction

    logic idle_like;
    assign idle_like = (state == ST_IDLE) || (state == ST_DONE);

    int unsigned valid_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             valid_run <= 0;
        else if (sig_ser_valid) valid_run <= valid_run + 1;
        else                    valid_run <= 0;
    end

    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pat_out != '0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |=> pat_out == pat_next($past(pat_out)));

    a_r5_unload_len: assert property (@(posedge clk) disable iff (!rst_n)
        valid_run <= SIG_W);

    a_r5_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ser_valid |-> !sig_ser);

    a_r5_valid_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        sig_ser_valid |-> !done);

    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    a_r6_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UNLOAD |=> state != ST_RUN);

    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like && start && test_len == '0 |=> sig_ser_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like && !start |=> $stable(pat_out));

endmodule

bind bist_engine bist_engine_chk #(
    .PAT_W    (PAT_W),
    .PAT_TAPS (PAT_TAPS),
    .SIG_W    (SIG_W),
    .LEN_W    (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .test_len      (test_len),
    .pat_out       (pat_out),
    .sig_ser       (sig_ser),
    .sig_ser_valid (sig_ser_valid),
    .done          (done),
    .pass          (pass),
    .state         (state)
);

// File: tb/sim_bist_engine.sv
module sim_bist_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] test_len = '0;
    logic [3:0]  golden = '0;
    logic [3:0]  pat_out;
    logic [3:0]  resp_in;
    logic        sig_ser;
    logic        sig_ser_valid;
    logic        done;
    logic        pass;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Circuit under test used by the bench.
    function automatic logic [3:0] cut(input logic [3:0] p);
        return {p[0] ^ p[3], p[1] & p[2], ~p[2], p[3] | p[1]};
    endfunction

    assign resp_in = cut(pat_out);

    bist_engine u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .test_len      (test_len),
        .golden        (golden),
        .pat_out       (pat_out),
        .resp_in       (resp_in),
        .sig_ser       (sig_ser),
        .sig_ser_valid (sig_ser_valid),
        .done          (done),
        .pass          (pass)
    );

    function automatic logic [3:0] pat_step(input logic [3:0] p);
        return {p[2:0], p[3] ^ p[2]};
    endfunction

    function automatic logic [3:0] sig_step(input logic [3:0] s, input logic [3:0] r);
        return {s[2:0], s[3] ^ s[0]} ^ r;
    endfunction

    function automatic logic [3:0] model_sig(input int len);
        logic [3:0] p = 4'b0001;
        logic [3:0] s = 4'b0000;
        for (int k = 0; k < len; k++) begin
            s = sig_step(s, cut(p));
            p = pat_step(p);
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    // Runs one test; inj_run pulses start at that RUN cycle (-1 none),
    // inj_unl pulses start at the first unload cycle.
    task automatic run_test(input int len, input logic [3:0] gold, input int inj_run,
                            input bit inj_unl);
        logic [3:0] exp_pat = 4'b0001;
        logic [3:0] exp_sig = 4'b0000;
        logic [3:0] got;
        bit         exp_pass;
        @(negedge clk);
        start    = 1'b1;
        test_len = 16'(len);
        golden   = gold;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < len; k++) begin
            check("R2 pattern", 32'(pat_out), 32'(exp_pat));
            check("R3 no unload during run", 32'(sig_ser_valid), 32'd0);
            if (k == inj_run) begin
                start    = 1'b1;
                test_len = 16'd7;
                golden   = ~gold;   // R10: late golden change
            end else begin
                start = 1'b0;
            end
            exp_sig = sig_step(exp_sig, cut(exp_pat));
            exp_pat = pat_step(exp_pat);
            @(negedge clk);
        end
        start = 1'b0;
        got = '0;
        for (int i = 0; i < 4; i++) begin
            check("R5 valid during unload", 32'(sig_ser_valid), 32'd1);
            check("R7 no done during unload", 32'(done), 32'd0);
            got = {got[2:0], sig_ser};
            start = (inj_unl && i == 0);
            @(negedge clk);
        end
        start = 1'b0;
        check(len == 0 ? "R8 zero-length signature" : "R4 signature MSB first",
              32'(got), 32'(exp_sig));
        check("R5 valid ends after 4", 32'(sig_ser_valid), 32'd0);
        check("R5 line quiet", 32'(sig_ser), 32'd0);
        check("R6 done raised", 32'(done), 32'd1);
        exp_pass = (exp_sig == gold);
        check("R6 pass verdict", 32'(pass), 32'(exp_pass));
        check("R9 pattern held", 32'(pat_out), 32'(exp_pat));
        repeat (2) @(negedge clk);
        check("R6 done held", 32'(done), 32'd1);
        check("R10 pass held", 32'(pass), 32'(exp_pass));
        check("R9 pattern still held", 32'(pat_out), 32'(exp_pat));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_b157);
        #(CLK_PERIOD * 2 + 1);
        check("R1 done in reset", 32'(done), 32'd0);
        check("R1 valid in reset", 32'(sig_ser_valid), 32'd0);
        check("R1 pass in reset", 32'(pass), 32'd0);
        check("R1 seed in reset", 32'(pat_out), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 seed after reset", 32'(pat_out), 32'h1);
        check("R1 done after reset", 32'(done), 32'd0);

        // Directed corners.
        run_test(1, model_sig(1), -1, 1'b0);
        run_test(15, model_sig(15), -1, 1'b0);
        run_test(0, 4'h0, -1, 1'b0);          // R8
        run_test(0, 4'h5, -1, 1'b0);          // R8 mismatch
        run_test(20, ~model_sig(20), -1, 1'b0);
        run_test(33, model_sig(33), 3, 1'b0); // R7 in RUN, R10
        run_test(9, model_sig(9), -1, 1'b1);  // R7 in UNLOAD
        run_test(16, model_sig(16), 0, 1'b1);

        // Random mix.
        for (int t = 0; t < 30; t++) begin
            int          len;
            logic [3:0]  g;
            int          inj;
            len = int'($urandom % 80);
            g   = ($urandom % 2 == 0) ? model_sig(len) : 4'($urandom);
            inj = (len > 2 && $urandom % 3 == 0) ? int'($urandom % len) : -1;
            run_test(len, g, inj, 1'($urandom % 2) && len > 0);
        end

        finish_run();
    end

endmodule